// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Edge Interrupts and Event Snapshot

This block is a 16-pin general-purpose I/O controller on a 16-bit register bus. Each pin can be turned into an output or an input. Outputs are driven from an output register. Each input can raise an interrupt on either a rising or a falling edge, chosen per pin, and each interrupt can be masked per pin. A single interrupt request summarises all pending status bits. Reading the status register clears only those pending bits whose mask bit is set.

An event mode picks one pin. Every time that pin changes, the block takes a snapshot of the whole input word into a latch register that software can read later. Pins come in as an asynchronous vector and pass through a two-flop synchronizer. Interrupt detection runs only while a functional clock-enable input is high. A nine-bit debounce setting is stored and can be read back, but nothing uses it.

Register reads are issued with a one-cycle strobe and answered one cycle later with a valid pulse. Writes take effect at the clock edge that samples them.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset the direction register reads 0xFFFF and the following read 0x0000: output, event mode, edge select, mask, status, debounce and event latch. `irq` is low and `pin_oe` is 0x0000.
- R2: The direction register is at offset 0x08, where bit value 1 means input. The output register is at offset 0x04. `pin_oe` is the inverse of direction, and `pin_out` is output AND NOT direction. Both reflect a register write from the cycle after that write.
- R3: An edge-select bit of 1 (offset 0x1C) makes a 0-to-1 change of the synchronized pin set that pin's status bit. A 1-to-0 change then sets nothing.
- R4: An edge-select bit of 0 makes a 1-to-0 change set the status bit. A 0-to-1 change then sets nothing.
- R5: A status bit is set only when three conditions hold: the pin is an input, its mask bit (offset 0x2C) is 0, and `fclk_en` is high.
- R6: A read of status (offset 0x24) returns the value held before the read. At that same edge the bits whose mask bit is 1 are cleared, while unmasked bits stay set. An edge that is detected in the same cycle as the read still sets its bit after the read.
- R7: `irq` is high whenever any status bit is set, and stays high until every status bit is cleared.
- R8: The event-mode register is at offset 0x18. Bit 0 enables event mode and bits 4:1 select a pin. While event mode is enabled, a change of the selected synchronized pin copies the full synchronized input word into the latch at offset 0x34. A change on any other pin, or any change while event mode is disabled, leaves the latch unchanged.
- R9: Only the low 5 bits of the event-mode register and the low 9 bits of the debounce register (offset 0x30) are stored. The upper bits read as 0.
- R10: Writes to the input (0x00), status and latch offsets, and to unmapped offsets, change nothing. Reads of unmapped offsets return 0.
- R11: A read strobe produces `bus_rvalid` with the data in the next cycle. Offset 0x00 returns the synchronized pin word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fclk_en | input | 1 | Functional clock enable; gates interrupt detection |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response pulse, one cycle after bus_rd |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
A read of the status register and a freshly detected edge can land on the same clock edge. The bench sets up this collision deliberately. First it leaves a pending bit behind on one pin and masks that pin. It then toggles a second, unmasked pin so that the change leaves the synchronizer exactly when the read strobe is sampled. The read must return only the old masked bit. A second read must show that the masked bit was cleared and that the new bit survived.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int IO_W  = 16;
    localparam int SEL_W = $clog2(IO_W);
    localparam int EVT_W = SEL_W + 1;
    localparam int DB_W  = 9;
    localparam int AW    = 6;

    localparam logic [AW-1:0] OFS_IN    = 6'h00;
    localparam logic [AW-1:0] OFS_OUT   = 6'h04;
    localparam logic [AW-1:0] OFS_DIR   = 6'h08;
    localparam logic [AW-1:0] OFS_EVT   = 6'h18;
    localparam logic [AW-1:0] OFS_EDGE  = 6'h1C;
    localparam logic [AW-1:0] OFS_STAT  = 6'h24;
    localparam logic [AW-1:0] OFS_MASK  = 6'h2C;
    localparam logic [AW-1:0] OFS_DEB   = 6'h30;
    localparam logic [AW-1:0] OFS_LATCH = 6'h34;

    typedef struct packed {
        logic [IO_W-1:0]  outv;
        logic [IO_W-1:0]  dir;
        logic [IO_W-1:0]  edge_sel;
        logic [IO_W-1:0]  mask;
        logic [IO_W-1:0]  status;
        logic [IO_W-1:0]  latch;
        logic [EVT_W-1:0] evt;
        logic [DB_W-1:0]  deb;
        logic             rvalid;
        logic [IO_W-1:0]  rdata;
    } gpio_state_t;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] smp_q,
    output logic [WIDTH-1:0] prev_q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            smp_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_in;
            smp_q  <= meta_q;
            prev_q <= smp_q;
        end
    end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] smp,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] edge_sel,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] mask,
    input  logic             fclk_en,
    output logic [WIDTH-1:0] hit,
    output logic [WIDTH-1:0] chg
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic rise_w;
        logic fall_w;
        assign rise_w = smp[i] & ~prev[i];
        assign fall_w = ~smp[i] & prev[i];
        assign chg[i] = smp[i] ^ prev[i];
        assign hit[i] = (edge_sel[i] ? rise_w : fall_w)
                        & dir[i] & ~mask[i] & fclk_en;
    end
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fclk_en,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [IO_W-1:0] bus_wdata,
    output logic [IO_W-1:0] bus_rdata,
    output logic            bus_rvalid,
    input  logic [IO_W-1:0] pin_in,
    output logic [IO_W-1:0] pin_out,
    output logic [IO_W-1:0] pin_oe,
    output logic            irq
);
    gpio_state_t st_d, st_q;
    logic [IO_W-1:0] smp_w, prev_w, hit_w, chg_w;
    logic [IO_W-1:0] rd_val;
    logic [IO_W-1:0] stat_base;

    gpio_evt_sync #(.WIDTH(IO_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .smp_q  (smp_w),
        .prev_q (prev_w)
    );

    gpio_evt_detect #(.WIDTH(IO_W)) u_detect (
        .smp      (smp_w),
        .prev     (prev_w),
        .edge_sel (st_q.edge_sel),
        .dir      (st_q.dir),
        .mask     (st_q.mask),
        .fclk_en  (fclk_en),
        .hit      (hit_w),
        .chg      (chg_w)
    );

    always_comb begin
        rd_val = '0;
        case (bus_addr)
            OFS_IN:    rd_val = smp_w;
            OFS_OUT:   rd_val = st_q.outv;
            OFS_DIR:   rd_val = st_q.dir;
            OFS_EVT:   rd_val = IO_W'(st_q.evt);
            OFS_EDGE:  rd_val = st_q.edge_sel;
            OFS_STAT:  rd_val = st_q.status;
            OFS_MASK:  rd_val = st_q.mask;
            OFS_DEB:   rd_val = IO_W'(st_q.deb);
            OFS_LATCH: rd_val = st_q.latch;
            default:   rd_val = '0;
        endcase

        st_d        = st_q;
        st_d.rvalid = bus_rd;
        st_d.rdata  = bus_rd ? rd_val : '0;

        if (bus_wr) begin
            case (bus_addr)
                OFS_OUT:  st_d.outv     = bus_wdata;
                OFS_DIR:  st_d.dir      = bus_wdata;
                OFS_EVT:  st_d.evt      = bus_wdata[EVT_W-1:0];
                OFS_EDGE: st_d.edge_sel = bus_wdata;
                OFS_MASK: st_d.mask     = bus_wdata;
                OFS_DEB:  st_d.deb      = bus_wdata[DB_W-1:0];
                default:  ;
            endcase
        end

        stat_base = st_q.status;
        if (bus_rd && bus_addr == OFS_STAT)
            stat_base = st_q.status & ~st_q.mask;
        st_d.status = stat_base | hit_w;

        if (st_q.evt[0] && chg_w[st_q.evt[EVT_W-1:1]])
            st_d.latch = smp_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.dir      <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign pin_oe     = ~st_q.dir;
    assign pin_out    = st_q.outv & ~st_q.dir;
    assign irq        = |st_q.status;

    AST_DRIVE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0)); // R2
    AST_STATUS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & ~$past(st_q.status)
          & ~($past(st_q.dir & ~st_q.mask) & {IO_W{$past(fclk_en)}})) == '0)); // R5
    AST_CLEAR_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((~st_q.status & $past(st_q.status) & ~$past(st_q.mask)) == '0)); // R6
    AST_IRQ_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|hit_w)); // R7
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q.evt[0]) |-> $stable(st_q.latch)); // R8
    AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R11
endmodule

// File: tb/gpio_evt_ctrl_bench.sv
module gpio_evt_ctrl_bench;
    import gpio_evt_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fclk_en = 1'b1;
    logic            bus_rd = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [IO_W-1:0] bus_wdata = '0;
    logic [IO_W-1:0] bus_rdata;
    logic            bus_rvalid;
    logic [IO_W-1:0] pin_in = '0;
    logic [IO_W-1:0] pin_out;
    logic [IO_W-1:0] pin_oe;
    logic            irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [IO_W-1:0] exp_q[$];
    string           tag_q[$];

    always #5 clk = ~clk;

    gpio_evt_ctrl u_gpio_evt_ctrl (
        .clk(clk), .rst_n(rst_n), .fclk_en(fclk_en),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected response: actual %h expected none", bus_rdata);
            end else begin
                automatic logic [IO_W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [IO_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [IO_W-1:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [IO_W-1:0] act, input logic [IO_W-1:0] e, input string t);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pin(input int i, input logic v);
        @(negedge clk);
        pin_in[i] = v;
        settle();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({15'd0, irq}, 16'h0, "R1 irq");
        chk(pin_oe, 16'h0000, "R1 pin_oe");
        rd(OFS_DIR, 16'hFFFF, "R1 dir");
        rd(OFS_OUT, 16'h0000, "R1 out");
        rd(OFS_STAT, 16'h0000, "R1 status");
        rd(OFS_LATCH, 16'h0000, "R1 latch");
        rd(OFS_EVT, 16'h0000, "R1 evt");
        rd(OFS_DEB, 16'h0000, "R1 debounce");
        // R2 drive
        wr(OFS_OUT, 16'h00FF);
        wr(OFS_DIR, 16'hFF0F);
        chk(pin_oe, 16'h00F0, "R2 oe");
        chk(pin_out, 16'h00F0, "R2 out");
        wr(OFS_DIR, 16'hFFFF);
        chk(pin_oe, 16'h0000, "R2 oe off");
        chk(pin_out, 16'h0000, "R2 out off");
        rd(OFS_OUT, 16'h00FF, "R2 out reg");
        // R3 rising
        wr(OFS_EDGE, 16'h0021);
        pin(0, 1'b1);
        rd(OFS_STAT, 16'h0001, "R3 rise");
        chk({15'd0, irq}, 16'h1, "R7 irq high");
        rd(OFS_STAT, 16'h0001, "R6 unmasked kept");
        wr(OFS_MASK, 16'h0001);
        rd(OFS_STAT, 16'h0001, "R6 masked read");
        rd(OFS_STAT, 16'h0000, "R6 masked cleared");
        chk({15'd0, irq}, 16'h0, "R7 irq low");
        wr(OFS_MASK, 16'h0000);
        pin(0, 1'b0);
        rd(OFS_STAT, 16'h0000, "R3 fall ignored");
        // R4 falling
        pin(1, 1'b1);
        rd(OFS_STAT, 16'h0000, "R4 rise ignored");
        pin(1, 1'b0);
        rd(OFS_STAT, 16'h0002, "R4 fall");
        wr(OFS_MASK, 16'h0002);
        rd(OFS_STAT, 16'h0002, "R4 read");
        rd(OFS_STAT, 16'h0000, "R4 clear");
        wr(OFS_MASK, 16'h0000);
        // R5 qualification
        pin(2, 1'b1);
        fclk_en = 1'b0;
        pin(2, 1'b0);
        fclk_en = 1'b1;
        rd(OFS_STAT, 16'h0000, "R5 clock gated");
        wr(OFS_DIR, 16'hFFF7);
        pin(3, 1'b1);
        pin(3, 1'b0);
        wr(OFS_DIR, 16'hFFFF);
        rd(OFS_STAT, 16'h0000, "R5 output pin");
        wr(OFS_MASK, 16'h0010);
        pin(4, 1'b1);
        pin(4, 1'b0);
        wr(OFS_MASK, 16'h0000);
        rd(OFS_STAT, 16'h0000, "R5 masked pin");
        // R6 collision of read-clear with new edge
        pin(2, 1'b1);
        pin(2, 1'b0);
        wr(OFS_MASK, 16'h0004);
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(negedge clk);
        rd(OFS_STAT, 16'h0004, "R6 collision read");
        rd(OFS_STAT, 16'h0020, "R6 collision after");
        chk({15'd0, irq}, 16'h1, "R7 irq collision");
        wr(OFS_MASK, 16'h0020);
        rd(OFS_STAT, 16'h0020, "R6 pin5 read");
        rd(OFS_STAT, 16'h0000, "R6 pin5 clear");
        wr(OFS_MASK, 16'h0000);
        // R8 event latch on pin 3
        wr(OFS_EVT, 16'h0007);
        @(negedge clk);
        pin_in[15:8] = 8'hA5;
        settle();
        rd(OFS_LATCH, 16'h0000, "R8 other pins");
        pin(3, 1'b1);
        rd(OFS_LATCH, 16'hA528, "R8 snapshot");
        pin(15, 1'b0);
        rd(OFS_LATCH, 16'hA528, "R8 non-selected");
        rd(OFS_IN, 16'h2528, "R11 input word");
        wr(OFS_EVT, 16'h0006);
        pin(3, 1'b0);
        rd(OFS_LATCH, 16'hA528, "R8 disabled");
        // R9 widths
        wr(OFS_EVT, 16'hFFFF);
        rd(OFS_EVT, 16'h001F, "R9 evt width");
        wr(OFS_EVT, 16'h0000);
        wr(OFS_DEB, 16'hFFFF);
        rd(OFS_DEB, 16'h01FF, "R9 debounce width");
        rd(OFS_EDGE, 16'h0021, "R3 edge reg");
        // R10 ignored writes
        wr(OFS_IN, 16'hFFFF);
        rd(OFS_IN, 16'h2520, "R10 input ro");
        wr(OFS_LATCH, 16'h1234);
        rd(OFS_LATCH, 16'hA528, "R10 latch ro");
        wr(6'h3C, 16'hFFFF);
        rd(6'h3C, 16'h0000, "R10 unmapped");
        rd(OFS_DIR, 16'hFFFF, "R10 dir untouched");
        wr(OFS_STAT, 16'h0000);
        rd(OFS_STAT, 16'h8008, "R10 status ro");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 missing responses: actual %0d expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule